// File: doc/BRIEF.md
# Micro-op Issue Port Allocator

The block sits between a reservation-station window and eight execution ports. Each cycle it looks at the micro-ops in a small window, picks those whose operands are ready, and binds each picked micro-op to a port that can run its operation class. Ports have different and overlapping capabilities, so the binding is a constrained assignment rather than a uniform wide issue. Every port takes at most one micro-op per cycle, and no micro-op is issued twice. A port that receives nothing drives its unit enable low so that the execution unit behind it can be clock- or power-gated.

Upstream logic writes one micro-op per cycle into the lowest free window slot. It gives the class, a hardware-thread bit, and an optional producer slot that the micro-op depends on. The allocator tracks fixed result latencies and wakes each dependent micro-op after the right number of cycles. Either thread may own an entry, and the thread bit plays no part in the choice of port. It is carried through to the port outputs unchanged. Arithmetic, memory access, renaming and retirement lie outside the block.

Top module: `uop_issue_alloc`

## Requirements
- R1: After a synchronous active-high reset, all unit enables are low, the window is empty, `win_full` is low and `alloc_slot` is 0.
- R2: A request on `alloc_vld` writes the micro-op into the lowest-numbered free slot, which `alloc_slot` shows in the same cycle. When all WIN slots hold micro-ops, `win_full` is high and a request is dropped.
- R3: Class codes are ALU=0, BR=1, FMA=2, LD=3, STA=4, STD=5. The ports accept the following classes:
  - port 0: ALU, BR, FMA
  - port 1: ALU, FMA
  - ports 2 and 3: LD, STA
  - port 4: STD
  - port 5: ALU
  - port 6: ALU, BR
  - port 7: STA
  - A port never receives a class outside this list.
- R4: Ports are filled in the order 4, 7, 6, 5, 2, 3, 0, 1. Each port takes the oldest ready micro-op that it accepts and that no earlier port took. As a result, a branch goes to port 6 before port 0, and a store-address goes to port 7 before ports 2 and 3.
- R5: The selection is made from the window state in one cycle and appears on the outputs after the next clock edge. For port p, the slot, class and thread fields sit at `port_slot[p*SW +: SW]`, `port_cls[p*3 +: 3]` and `port_thr[p]`.
- R6: An issued micro-op leaves the window at the edge where it issues. Its slot can be allocated again in the following cycle.
- R7: A micro-op that depends on an FMA reaches the outputs exactly 5 cycles after that FMA.
- R8: A dependent of a load reaches the outputs 4 cycles after the load. A dependent of any other class can follow 1 cycle after its producer, which allows back-to-back issue.
- R9: A dependency on a slot that holds no micro-op at allocation time counts as satisfied. If the producer issues in the allocation cycle, the latency countdown starts at that edge.
- R10: The thread bit has no effect on port binding and is copied to `port_thr`.
- R11: `unit_en[p]` is high in exactly the cycles in which port p carries an issued micro-op. It is low on every idle port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Write a micro-op into the window |
| alloc_cls | input | 3 | Operation class of the new micro-op |
| alloc_thr | input | 1 | Hardware thread of the new micro-op |
| alloc_dep_vld | input | 1 | New micro-op waits on a producer |
| alloc_dep_slot | input | SW | Window slot of the producer |
| alloc_slot | output | SW | Slot the next allocation will use |
| win_full | output | 1 | All slots occupied |
| unit_en | output | 8 | Per-port issue valid and unit enable |
| port_slot | output | 8*SW | Issued slot per port |
| port_cls | output | 24 | Issued class per port |
| port_thr | output | 8 | Issued thread per port |

## Verification
`alloc_slot` and `win_full` are checked in the same cycle as the stimulus. The port outputs are checked one edge after the cycle whose window state produced them. The bench drives inputs on the falling edge and keeps a reference window model that advances one step per clock. It compares each cycle's registered outputs with the model's selection from the previous step. Wakeup spacing is therefore measured in whole clock edges: 5 for FMA producers, 4 for loads and 1 otherwise. A dependent that shows up one cycle early or late does not match the model.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int NPORT = 8;
  localparam int CLS_W = 3;

  localparam logic [CLS_W-1:0] CLS_ALU = 3'd0;
  localparam logic [CLS_W-1:0] CLS_BR  = 3'd1;
  localparam logic [CLS_W-1:0] CLS_FMA = 3'd2;
  localparam logic [CLS_W-1:0] CLS_LD  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_STA = 3'd4;
  localparam logic [CLS_W-1:0] CLS_STD = 3'd5;

  // R4: fill order, most restrictive ports first
  function automatic int fill_port(input int k);
    case (k)
      0: return 4;
      1: return 7;
      2: return 6;
      3: return 5;
      4: return 2;
      5: return 3;
      6: return 0;
      default: return 1;
    endcase
  endfunction

  // R3: port capability map
  function automatic logic port_takes(input int p, input logic [CLS_W-1:0] c);
    case (p)
      0: return (c == CLS_ALU) || (c == CLS_BR) || (c == CLS_FMA);
      1: return (c == CLS_ALU) || (c == CLS_FMA);
      2, 3: return (c == CLS_LD) || (c == CLS_STA);
      4: return (c == CLS_STD);
      5: return (c == CLS_ALU);
      6: return (c == CLS_ALU) || (c == CLS_BR);
      7: return (c == CLS_STA);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uop_window.sv
module uop_window
  import uop_pkg::*;
#(
  parameter int WIN     = 8,
  parameter int FMA_LAT = 5,
  parameter int LD_LAT  = 4,
  parameter int ALU_LAT = 1,
  localparam int SW     = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int MAXLAT = (FMA_LAT > LD_LAT) ? ((FMA_LAT > ALU_LAT) ? FMA_LAT : ALU_LAT)
                                             : ((LD_LAT > ALU_LAT) ? LD_LAT : ALU_LAT),
  localparam int CNT_W  = $clog2(MAXLAT + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            alloc_vld,
  input  logic [CLS_W-1:0]                alloc_cls,
  input  logic                            alloc_thr,
  input  logic                            alloc_dep_vld,
  input  logic [SW-1:0]                   alloc_dep_slot,
  input  logic [WIN-1:0]                  issue_mask,
  output logic [WIN-1:0]                  vld,
  output logic [WIN-1:0]                  elig,
  output logic [WIN-1:0][CLS_W-1:0]       ent_cls,
  output logic [WIN-1:0]                  ent_thr,
  output logic [WIN-1:0][WIN-1:0]         older,
  output logic [SW-1:0]                   free_slot,
  output logic                            full
);
  logic [WIN-1:0]             pend;
  logic [WIN-1:0][SW-1:0]     dep;
  logic [WIN-1:0][CNT_W-1:0]  cnt;
  logic                       found;
  logic                       do_alloc;
  logic                       dep_live;

  // countdown preload: latency minus one, so the dependent issues LAT edges later
  function automatic logic [CNT_W-1:0] lat_m1(input logic [CLS_W-1:0] c);
    if (c == CLS_FMA)     return CNT_W'(FMA_LAT - 1);
    else if (c == CLS_LD) return CNT_W'(LD_LAT - 1);
    else                  return CNT_W'(ALU_LAT - 1);
  endfunction

  always_comb begin
    free_slot = '0;
    found     = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (!vld[i] && !found) begin
        free_slot = SW'(i);
        found     = 1'b1;
      end
    end
    full     = !found;
    do_alloc = alloc_vld && !full;
    dep_live = alloc_dep_vld && vld[alloc_dep_slot];
  end

  always_comb begin
    for (int i = 0; i < WIN; i++)
      elig[i] = vld[i] && !pend[i] && (cnt[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      pend  <= '0;
      cnt   <= '0;
      older <= '0;
      dep   <= '0;
      ent_cls <= '0;
      ent_thr <= '0;
    end else begin
      for (int e = 0; e < WIN; e++) begin
        if (vld[e] && pend[e] && issue_mask[dep[e]]) begin
          pend[e] <= 1'b0;
          cnt[e]  <= lat_m1(ent_cls[dep[e]]);
        end else if (cnt[e] != '0) begin
          cnt[e] <= cnt[e] - 1'b1;
        end
        if (issue_mask[e]) vld[e] <= 1'b0;
      end
      if (do_alloc) begin
        vld[free_slot]     <= 1'b1;
        ent_cls[free_slot] <= alloc_cls;
        ent_thr[free_slot] <= alloc_thr;
        dep[free_slot]     <= alloc_dep_slot;
        if (dep_live && issue_mask[alloc_dep_slot]) begin
          pend[free_slot] <= 1'b0;
          cnt[free_slot]  <= lat_m1(ent_cls[alloc_dep_slot]);
        end else begin
          pend[free_slot] <= dep_live;
          cnt[free_slot]  <= '0;
        end
        older[free_slot] <= '0;
        for (int j = 0; j < WIN; j++)
          if (SW'(j) != free_slot) older[j][free_slot] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uop_oldest.sv
module uop_oldest #(
  parameter int WIN = 8,
  localparam int SW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic [WIN-1:0]          cand,
  input  logic [WIN-1:0][WIN-1:0] older,
  output logic                    hit,
  output logic [WIN-1:0]          sel,
  output logic [SW-1:0]           idx
);
  logic [WIN-1:0] beaten;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      beaten[i] = 1'b0;
      for (int j = 0; j < WIN; j++)
        if (j != i && cand[j] && !older[i][j]) beaten[i] = 1'b1;
    end
    sel = '0;
    idx = '0;
    for (int i = 0; i < WIN; i++) begin
      if (cand[i] && !beaten[i]) begin
        sel[i] = 1'b1;
        idx    = SW'(i);
      end
    end
    hit = |cand;
  end
endmodule

// File: rtl/uop_port_pick.sv
module uop_port_pick
  import uop_pkg::*;
#(
  parameter int WIN = 8,
  localparam int SW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic [WIN-1:0]            elig,
  input  logic [WIN-1:0][CLS_W-1:0] ent_cls,
  input  logic [WIN-1:0][WIN-1:0]   older,
  output logic [NPORT-1:0]          grant_vld,
  output logic [NPORT-1:0][SW-1:0]  grant_slot,
  output logic [WIN-1:0]            issue_mask
);
  logic [WIN-1:0] taken [NPORT+1];
  assign taken[0] = '0;

  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_fill
      localparam int P = fill_port(k);
      logic [WIN-1:0] acc;
      logic [WIN-1:0] cand;
      logic [WIN-1:0] sel;
      logic [SW-1:0]  idx;
      logic           hit;

      always_comb begin
        for (int i = 0; i < WIN; i++)
          acc[i] = port_takes(P, ent_cls[i]);
      end
      assign cand = elig & acc & ~taken[k];

      uop_oldest #(.WIN(WIN)) u_old (
        .cand  (cand),
        .older (older),
        .hit   (hit),
        .sel   (sel),
        .idx   (idx)
      );

      assign taken[k+1]    = taken[k] | sel;
      assign grant_vld[P]  = hit;
      assign grant_slot[P] = idx;
    end
  endgenerate

  assign issue_mask = taken[NPORT];
endmodule

// File: rtl/uop_issue_alloc.sv
module uop_issue_alloc
  import uop_pkg::*;
#(
  parameter int WIN     = 8,
  parameter int FMA_LAT = 5,
  parameter int LD_LAT  = 4,
  parameter int ALU_LAT = 1,
  localparam int SW     = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc_vld,
  input  logic [CLS_W-1:0]       alloc_cls,
  input  logic                   alloc_thr,
  input  logic                   alloc_dep_vld,
  input  logic [SW-1:0]          alloc_dep_slot,
  output logic [SW-1:0]          alloc_slot,
  output logic                   win_full,
  output logic [NPORT-1:0]       unit_en,
  output logic [NPORT*SW-1:0]    port_slot,
  output logic [NPORT*CLS_W-1:0] port_cls,
  output logic [NPORT-1:0]       port_thr
);
  logic [WIN-1:0]             win_vld;
  logic [WIN-1:0]             elig;
  logic [WIN-1:0][CLS_W-1:0]  ent_cls;
  logic [WIN-1:0]             ent_thr;
  logic [WIN-1:0][WIN-1:0]    older;
  logic [WIN-1:0]             issue_mask;
  logic [NPORT-1:0]           grant_vld;
  logic [NPORT-1:0][SW-1:0]   grant_slot;

  uop_window #(
    .WIN(WIN), .FMA_LAT(FMA_LAT), .LD_LAT(LD_LAT), .ALU_LAT(ALU_LAT)
  ) u_win (
    .clk            (clk),
    .rst            (rst),
    .alloc_vld      (alloc_vld),
    .alloc_cls      (alloc_cls),
    .alloc_thr      (alloc_thr),
    .alloc_dep_vld  (alloc_dep_vld),
    .alloc_dep_slot (alloc_dep_slot),
    .issue_mask     (issue_mask),
    .vld            (win_vld),
    .elig           (elig),
    .ent_cls        (ent_cls),
    .ent_thr        (ent_thr),
    .older          (older),
    .free_slot      (alloc_slot),
    .full           (win_full)
  );

  uop_port_pick #(.WIN(WIN)) u_pick (
    .elig       (elig),
    .ent_cls    (ent_cls),
    .older      (older),
    .grant_vld  (grant_vld),
    .grant_slot (grant_slot),
    .issue_mask (issue_mask)
  );

  // R5/R11: registered port outputs; an idle port drops its enable
  always_ff @(posedge clk) begin
    if (rst) begin
      unit_en   <= '0;
      port_slot <= '0;
      port_cls  <= '0;
      port_thr  <= '0;
    end else begin
      unit_en <= grant_vld;
      for (int p = 0; p < NPORT; p++) begin
        port_slot[p*SW +: SW]       <= grant_slot[p];
        port_cls[p*CLS_W +: CLS_W]  <= ent_cls[grant_slot[p]];
        port_thr[p]                 <= ent_thr[grant_slot[p]];
      end
    end
  end
endmodule

// File: rtl/uop_issue_alloc_chk.sv
module uop_issue_alloc_chk
  import uop_pkg::*;
#(
  parameter int WIN = 8,
  localparam int SW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NPORT-1:0]       unit_en,
  input logic [NPORT*SW-1:0]    port_slot,
  input logic [NPORT*CLS_W-1:0] port_cls,
  input logic [WIN-1:0]         win_vld
);
  logic           rst_q = 1'b0;
  logic [WIN-1:0] vld_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    vld_q <= win_vld;
  end

  function automatic logic dup_slots(input logic [NPORT-1:0] en, input logic [NPORT*SW-1:0] s);
    logic d;
    d = 1'b0;
    for (int a = 0; a < NPORT; a++)
      for (int b = a + 1; b < NPORT; b++)
        if (en[a] && en[b] && s[a*SW +: SW] == s[b*SW +: SW]) d = 1'b1;
    return d;
  endfunction

  // R1: cycle after reset shows no issue
  p_reset_idle_r1: assert property (@(posedge clk) rst_q |-> (unit_en == '0));

  // R4: a micro-op goes to one port only
  p_no_double_issue_r4: assert property (@(posedge clk) disable iff (rst)
    !dup_slots(unit_en, port_slot));

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      // R3: class legal for its port
      p_cap_ok_r3: assert property (@(posedge clk) disable iff (rst)
        unit_en[p] |-> port_takes(p, port_cls[p*CLS_W +: CLS_W]));
      // R4: issued slot held a micro-op in the selecting cycle
      p_from_valid_r4: assert property (@(posedge clk) disable iff (rst)
        unit_en[p] |-> vld_q[port_slot[p*SW +: SW]]);
      // R6: issued slot is free right after issue
      p_freed_r6: assert property (@(posedge clk) disable iff (rst)
        unit_en[p] |-> !win_vld[port_slot[p*SW +: SW]]);
    end
  endgenerate
endmodule

bind uop_issue_alloc uop_issue_alloc_chk #(.WIN(WIN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .unit_en   (unit_en),
  .port_slot (port_slot),
  .port_cls  (port_cls),
  .win_vld   (win_vld)
);

// File: tb/uop_issue_alloc_tb_top.sv
`timescale 1ns/1ps
module uop_issue_alloc_tb_top;
  localparam int WIN = 8;
  localparam int SW  = 3;
  localparam int NP  = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            alloc_vld = 1'b0;
  logic [2:0]      alloc_cls = '0;
  logic            alloc_thr = 1'b0;
  logic            alloc_dep_vld = 1'b0;
  logic [SW-1:0]   alloc_dep_slot = '0;
  logic [SW-1:0]   alloc_slot;
  logic            win_full;
  logic [NP-1:0]   unit_en;
  logic [NP*SW-1:0] port_slot;
  logic [NP*3-1:0] port_cls;
  logic [NP-1:0]   port_thr;

  always #2.5 clk = ~clk;

  uop_issue_alloc #(.WIN(WIN)) dut_i (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_cls(alloc_cls),
    .alloc_thr(alloc_thr), .alloc_dep_vld(alloc_dep_vld), .alloc_dep_slot(alloc_dep_slot),
    .alloc_slot(alloc_slot), .win_full(win_full), .unit_en(unit_en),
    .port_slot(port_slot), .port_cls(port_cls), .port_thr(port_thr)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  bit       m_vld [WIN];
  bit [2:0] m_cls [WIN];
  bit       m_thr [WIN];
  bit       m_pend[WIN];
  int       m_dep [WIN];
  int       m_cnt [WIN];
  int       m_seq [WIN];
  int       seqc = 0;
  int       last_slot = 0;
  bit [NP-1:0] e_en;
  int       e_slot[NP];
  bit [2:0] e_cls [NP];
  bit       e_thr [NP];
  string    ptag = "R1 reset";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lat(bit [2:0] c);
    if (c == 3'd2) return 5;
    if (c == 3'd3) return 4;
    return 1;
  endfunction

  function automatic bit takes(int p, bit [2:0] c);
    case (p)
      0: return c == 0 || c == 1 || c == 2;
      1: return c == 0 || c == 2;
      2, 3: return c == 3 || c == 4;
      4: return c == 5;
      5: return c == 0;
      6: return c == 0 || c == 1;
      7: return c == 4;
      default: return 0;
    endcase
  endfunction

  function automatic int order_port(int k);
    int ord[NP] = '{4, 7, 6, 5, 2, 3, 0, 1};
    return ord[k];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < WIN; i++) begin
      m_vld[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; m_dep[i] = 0; m_seq[i] = 0;
      m_cls[i] = 0; m_thr[i] = 0;
    end
    e_en = '0;
  endtask

  task automatic check_ports(string tag);
    check(unit_en == e_en, tag, "unit_en", unit_en, e_en);
    for (int p = 0; p < NP; p++) begin
      if (e_en[p] && unit_en[p]) begin
        longint act, exp;
        act = {port_slot[p*SW +: SW], port_cls[p*3 +: 3], port_thr[p]};
        exp = {3'(e_slot[p]), e_cls[p], e_thr[p]};
        check(act == exp, tag, $sformatf("port%0d {slot,cls,thr}", p), act, exp);
      end
    end
  endtask

  task automatic step(bit av, bit [2:0] c, bit t, bit dv, int ds, string tag);
    int  fr;
    bit  full;
    bit  iss[WIN];
    bit  a_pend;
    int  a_cnt;
    check_ports(ptag);
    fr = -1;
    for (int i = WIN - 1; i >= 0; i--) if (!m_vld[i]) fr = i;
    full = (fr < 0);
    check(win_full == full, tag, "win_full (R2)", win_full, full);
    if (!full) check(alloc_slot == fr, tag, "alloc_slot (R2)", alloc_slot, fr);
    // expected picks (R4)
    for (int i = 0; i < WIN; i++) iss[i] = 0;
    e_en = '0;
    for (int k = 0; k < NP; k++) begin
      int p, best;
      p = order_port(k);
      best = -1;
      for (int i = 0; i < WIN; i++) begin
        if (m_vld[i] && !m_pend[i] && m_cnt[i] == 0 && !iss[i] && takes(p, m_cls[i]))
          if (best < 0 || m_seq[i] < m_seq[best]) best = i;
      end
      if (best >= 0) begin
        iss[best] = 1; e_en[p] = 1; e_slot[p] = best;
        e_cls[p] = m_cls[best]; e_thr[p] = m_thr[best];
      end
    end
    // allocation dependency from pre-edge state (R9)
    a_pend = 0; a_cnt = 0;
    if (dv && m_vld[ds]) begin
      if (iss[ds]) a_cnt = lat(m_cls[ds]) - 1;
      else a_pend = 1;
    end
    for (int e = 0; e < WIN; e++) begin
      if (m_vld[e] && m_pend[e] && iss[m_dep[e]]) begin
        m_pend[e] = 0; m_cnt[e] = lat(m_cls[m_dep[e]]) - 1;
      end else if (m_cnt[e] > 0) m_cnt[e]--;
      if (iss[e]) m_vld[e] = 0;
    end
    if (av && !full) begin
      m_vld[fr] = 1; m_cls[fr] = c; m_thr[fr] = t; m_dep[fr] = ds;
      m_pend[fr] = a_pend; m_cnt[fr] = a_cnt; m_seq[fr] = seqc++;
      last_slot = fr;
    end
    alloc_vld = av; alloc_cls = c; alloc_thr = t;
    alloc_dep_vld = dv; alloc_dep_slot = 3'(ds);
    ptag = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  // group of micro-ops all woken by one FMA so they compete in one cycle
  task automatic group(bit t, string tag);
    int h;
    step(1, 3'd2, t, 0, 0, tag);
    step(1, 3'd2, t, 1, last_slot, tag);
    h = last_slot;
    step(1, 3'd1, t, 1, h, tag);
    step(1, 3'd1, t, 1, h, tag);
    step(1, 3'd4, t, 1, h, tag);
    step(1, 3'd4, t, 1, h, tag);
    step(1, 3'd4, t, 1, h, tag);
    idle(8, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(unit_en == '0, "R1", "unit_en after reset", unit_en, 0);
    check(win_full == 1'b0, "R1", "win_full after reset", win_full, 0);
    check(alloc_slot == '0, "R1", "alloc_slot after reset", alloc_slot, 0);

    // R3: one of each class
    for (int c = 0; c < 6; c++) step(1, 3'(c), 0, 0, 0, "R3 classes");
    idle(3, "R11 idle");
    // R4: port preference among simultaneous wakeups
    group(0, "R4 preference");
    // R10: same pattern on the other thread, and mixed
    group(1, "R10 thread1");
    step(1, 3'd1, 1, 0, 0, "R10 mixed");
    step(1, 3'd1, 0, 0, 0, "R10 mixed");
    idle(3, "R10 mixed");
    // R7: FMA wakeup spacing
    step(1, 3'd2, 0, 0, 0, "R7 fma");
    step(1, 3'd0, 0, 1, last_slot, "R7 fma dep");
    idle(8, "R7 fma");
    // R8: load latency and back-to-back ALU
    step(1, 3'd3, 0, 0, 0, "R8 load");
    step(1, 3'd0, 0, 1, last_slot, "R8 load dep");
    idle(6, "R8 load");
    step(1, 3'd0, 0, 0, 0, "R8 alu");
    step(1, 3'd0, 1, 1, last_slot, "R8 alu dep");
    idle(3, "R8 alu");
    // R9: dependency on an empty slot
    step(1, 3'd0, 0, 1, 5, "R9 empty dep");
    idle(3, "R9 empty dep");
    // R2: FMA chain fills the window, extra requests dropped
    step(1, 3'd2, 0, 0, 0, "R2 fill");
    for (int i = 0; i < 14; i++) step(1, 3'd2, 0, 1, last_slot, "R2 fill");
    idle(60, "R2 drain");
    // R6: slot reuse
    for (int i = 0; i < 5; i++) step(1, 3'd0, 0, 0, 0, "R6 reuse");
    idle(3, "R11 idle");
    // R5 random mix
    for (int i = 0; i < 4000; i++) begin
      bit av, dv;
      av = ($urandom % 10) < 7;
      dv = ($urandom % 2) == 1;
      step(av, 3'($urandom % 6), 1'($urandom), dv, int'($urandom % WIN), "R5 random");
    end
    idle(40, "R11 tail");
    check_ports(ptag);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule